// File: doc/BRIEF.md
# Dual-Channel UART Host Register Interface

This block is the processor-facing side of a two-channel serial controller. Both channels hang off one 8-bit host data bus. Each channel has its own active-low select line. A 3-bit address picks one of eight register locations in a channel, and active-low read and write strobes carry out the access. Each channel keeps a divisor latch pair, a line-control register and a scratch register. The serial engines, FIFOs, baud generation, interrupts and modem pins live elsewhere, so this block ends at register storage and readback.

Reads are combinational from the bus pins, so a read needs no clock edge to complete. Writes pass the strobes, address and data through a two-stage synchronizer into the system clock domain. A small state machine then commits the write when the write strobe is released. The machine has three states:
- `ST_IDLE`: it moves to `ST_HOLD` once a synchronized write strobe is seen low with any select active.
- `ST_HOLD`: it re-captures address, data and selects every cycle the strobe stays low, and moves to `ST_COMMIT` when the strobe rises.
- `ST_COMMIT`: it issues a single-cycle register update to every channel that was selected, then returns to `ST_IDLE`.

Asserting both selects during a write updates both channels at once. The divisor bytes share addresses 0 and 1 and can be reached only while line-control bit 7 is set. While both divisor bytes of a channel are zero, those two addresses return a revision code and a device code instead.

Top module: `duart_hostif`

## Requirements
- R1: After reset, every register location of both channels reads 0x00, except line control (address 3), which reads 0x1D.
- R2: A write with only one channel selected updates the addressed register of that channel and leaves the other channel unchanged.
- R3: A write with both selects active stores the same data into the addressed register of both channels.
- R4: A read with both selects active returns channel A's value.
- R5: The bus output enable is high exactly when at least one select and the read strobe are both low.
- R6: While line-control bit 7 is 0, addresses 0 and 1 read 0x00 and writes to them leave the divisor bytes unchanged. While bit 7 is 1, address 0 reads and writes the divisor low byte and address 1 reads and writes the divisor high byte.
- R7: While line-control bit 7 is 1 and both divisor bytes are 0x00, address 0 reads 0x01 (revision) and address 1 reads 0x06 (device code).
- R8: Addresses 2, 4, 5 and 6 read 0x00 and ignore writes. Address 7 is a read/write scratch register.
- R9: A write takes effect once, only after the write strobe is released, and then shows on a read within 6 clock cycles.
- R10: A write strobe pulse with neither select active changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset |
| cs_a_n | input | 1 | Channel A select, active low |
| cs_b_n | input | 1 | Channel B select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register location |
| d_in | input | 8 | Write data from host |
| d_out | output | 8 | Read data to host |
| d_oe | output | 1 | Drive enable for the shared bus |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, device code 0x06, revision 0x01 and a line-control reset value of 0x1D. With these values, every one of the eight addresses can be swept under all three select patterns, both with divisor access off and with it on. An arithmetic model in the bench predicts every readback. Explicit sequences cover the identification window, including leaving it through either divisor byte, and a write strobe with no select active.

// File: rtl/duart_hostif_pkg.sv
package duart_hostif_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HOLD   = 2'd1,
        ST_COMMIT = 2'd2
    } wr_state_t;

    localparam logic [2:0] LOC_DIV_LO  = 3'd0;
    localparam logic [2:0] LOC_DIV_HI  = 3'd1;
    localparam logic [2:0] LOC_LINE    = 3'd3;
    localparam logic [2:0] LOC_SCRATCH = 3'd7;
endpackage

// File: rtl/duart_sync.sv
module duart_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/duart_wr_fsm.sv
module duart_wr_fsm
    import duart_hostif_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_s_n,
    input  logic          cs_a_s_n,
    input  logic          cs_b_s_n,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    output logic          wen_a,
    output logic          wen_b,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata
);
    wr_state_t     state, state_nx;
    logic          sel_a_q, sel_b_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          any_sel;

    assign any_sel = !cs_a_s_n || !cs_b_s_n;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (!wr_s_n && any_sel) state_nx = ST_HOLD;
            ST_HOLD:   if (wr_s_n)             state_nx = ST_COMMIT;
            ST_COMMIT:                         state_nx = ST_IDLE;
            default:                           state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_a_q <= 1'b0;
            sel_b_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if (!wr_s_n && any_sel && (state == ST_IDLE || state == ST_HOLD)) begin
            sel_a_q <= !cs_a_s_n;
            sel_b_q <= !cs_b_s_n;
            addr_q  <= addr_s;
            data_q  <= data_s;
        end
    end

    always_comb begin
        wen_a = (state == ST_COMMIT) && sel_a_q;
        wen_b = (state == ST_COMMIT) && sel_b_q;
        waddr = addr_q;
        wdata = data_q;
    end

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (wen_a || wen_b) |=> !(wen_a || wen_b)); // R9
    AST_COMMIT_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (wen_a || wen_b) |-> $past(wr_s_n)); // R9
endmodule

// File: rtl/duart_chan_regs.sv
module duart_chan_regs
    import duart_hostif_pkg::*;
#(
    parameter int          AW        = 3,
    parameter int          DW        = 8,
    parameter logic [DW-1:0] LCR_RESET = 8'h1D,
    parameter logic [DW-1:0] ID_CODE   = 8'h06,
    parameter logic [DW-1:0] REV_CODE  = 8'h01
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wen,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] div_lo, div_hi, line, scratch;
    logic          div_acc, div_zero;

    assign div_acc  = line[DW-1];
    assign div_zero = (div_lo == '0) && (div_hi == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_lo  <= '0;
            div_hi  <= '0;
            line    <= LCR_RESET;
            scratch <= '0;
        end else if (wen) begin
            if (waddr == LOC_DIV_LO && div_acc) div_lo  <= wdata;
            if (waddr == LOC_DIV_HI && div_acc) div_hi  <= wdata;
            if (waddr == LOC_LINE)              line    <= wdata;
            if (waddr == LOC_SCRATCH)           scratch <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (raddr == LOC_DIV_LO && div_acc)       rdata = div_zero ? REV_CODE : div_lo;
        else if (raddr == LOC_DIV_HI && div_acc)  rdata = div_zero ? ID_CODE  : div_hi;
        else if (raddr == LOC_LINE)               rdata = line;
        else if (raddr == LOC_SCRATCH)            rdata = scratch;
    end

    AST_DIV_GUARD: assert property (@(posedge clk) disable iff (rst)
        (wen && !div_acc) |=> ($stable(div_lo) && $stable(div_hi))); // R6
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wen |=> ($stable(line) && $stable(scratch))); // R10
endmodule

// File: rtl/duart_hostif.sv
module duart_hostif #(
    parameter int         AW          = 3,
    parameter int         DW          = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] LCR_RESET   = 8'h1D,
    parameter logic [7:0] ID_CODE     = 8'h06,
    parameter logic [7:0] REV_CODE    = 8'h01
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_a_n,
    input  logic          cs_b_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] d_in,
    output logic [DW-1:0] d_out,
    output logic          d_oe
);
    localparam int NCH = 2;
    localparam int SW  = 3 + AW + DW;

    logic [SW-1:0] sync_in, sync_out;
    logic          wr_s_n, cs_a_s_n, cs_b_s_n;
    logic [AW-1:0] addr_s, waddr;
    logic [DW-1:0] data_s, wdata;
    logic [NCH-1:0] wen;
    logic [DW-1:0] ch_rd [NCH];

    assign sync_in = {wr_n, cs_a_n, cs_b_n, addr, d_in};
    assign {wr_s_n, cs_a_s_n, cs_b_s_n, addr_s, data_s} = sync_out;

    duart_sync #(
        .WIDTH  (SW),
        .STAGES (SYNC_STAGES),
        .RST_VAL({3'b111, {(AW+DW){1'b0}}})
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sync_in),
        .q   (sync_out)
    );

    duart_wr_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wr_s_n   (wr_s_n),
        .cs_a_s_n (cs_a_s_n),
        .cs_b_s_n (cs_b_s_n),
        .addr_s   (addr_s),
        .data_s   (data_s),
        .wen_a    (wen[0]),
        .wen_b    (wen[1]),
        .waddr    (waddr),
        .wdata    (wdata)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        duart_chan_regs #(
            .AW(AW), .DW(DW), .LCR_RESET(LCR_RESET),
            .ID_CODE(ID_CODE), .REV_CODE(REV_CODE)
        ) u_regs (
            .clk   (clk),
            .rst   (rst),
            .wen   (wen[c]),
            .waddr (waddr),
            .wdata (wdata),
            .raddr (addr),
            .rdata (ch_rd[c])
        );
    end

    assign d_oe  = (!cs_a_n || !cs_b_n) && !rd_n;
    assign d_out = d_oe ? (!cs_a_n ? ch_rd[0] : ch_rd[1]) : '0;

    AST_OE_NEEDS_RD: assert property (@(posedge clk) disable iff (rst)
        d_oe |-> !rd_n); // R5
    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        d_oe |-> (!cs_a_n || !cs_b_n)); // R5
    AST_BOTH_READ_A: assert property (@(posedge clk) disable iff (rst)
        (d_oe && !cs_a_n && !cs_b_n) |-> (d_out == ch_rd[0])); // R4
    AST_NO_DUAL_UPDATE_WITHOUT_SEL: assert property (@(posedge clk) disable iff (rst)
        (wen != '0) |-> $past(!cs_a_s_n || !cs_b_s_n, 2)); // R10
endmodule

// File: tb/duart_hostif_tb.sv
module duart_hostif_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_a_n = 1'b1, cs_b_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] d_in = '0;
    logic [7:0] d_out;
    logic       d_oe;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_lo [2];
    logic [7:0] m_hi [2];
    logic [7:0] m_ln [2];
    logic [7:0] m_sp [2];

    always #10 clk = ~clk;

    duart_hostif u_dut (
        .clk(clk), .rst(rst), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
        .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .d_in(d_in),
        .d_out(d_out), .d_oe(d_oe)
    );

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog expired (R9) actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [7:0] expect_rd(int ch, logic [2:0] a);
        logic acc = m_ln[ch][7];
        logic z = (m_lo[ch] == 8'h00) && (m_hi[ch] == 8'h00);
        case (a)
            3'd0: return acc ? (z ? 8'h01 : m_lo[ch]) : 8'h00;
            3'd1: return acc ? (z ? 8'h06 : m_hi[ch]) : 8'h00;
            3'd3: return m_ln[ch];
            3'd7: return m_sp[ch];
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_wr(bit sa, bit sb, logic [2:0] a, logic [7:0] d);
        for (int ch = 0; ch < 2; ch++) begin
            if ((ch == 0 && sa) || (ch == 1 && sb)) begin
                if (a == 3'd0 && m_ln[ch][7]) m_lo[ch] = d;
                if (a == 3'd1 && m_ln[ch][7]) m_hi[ch] = d;
                if (a == 3'd3) m_ln[ch] = d;
                if (a == 3'd7) m_sp[ch] = d;
            end
        end
    endtask

    task automatic bus_wr(bit sa, bit sb, logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        cs_a_n = !sa; cs_b_n = !sb; addr = a; d_in = d; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_a_n = 1'b1; cs_b_n = 1'b1;
        repeat (6) @(negedge clk);
        model_wr(sa, sb, a, d);
    endtask

    task automatic bus_rd(bit sa, bit sb, logic [2:0] a, output logic [7:0] v, output logic oe);
        @(negedge clk);
        cs_a_n = !sa; cs_b_n = !sb; addr = a; rd_n = 1'b0;
        #2;
        v = d_out; oe = d_oe;
        @(negedge clk);
        rd_n = 1'b1; cs_a_n = 1'b1; cs_b_n = 1'b1;
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_all(string req);
        logic [7:0] v;
        logic oe;
        for (int ch = 0; ch < 2; ch++) begin
            for (int a = 0; a < 8; a++) begin
                bus_rd(ch == 0, ch == 1, 3'(a), v, oe);
                chk(req, v, expect_rd(ch, 3'(a)));
            end
        end
    endtask

    initial begin
        logic [7:0] v;
        logic oe;
        for (int ch = 0; ch < 2; ch++) begin
            m_lo[ch] = 8'h00; m_hi[ch] = 8'h00; m_ln[ch] = 8'h1D; m_sp[ch] = 8'h00;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset values
        chk_all("R1");

        // R5 enable only with select and read strobe
        #2; checks++;
        if (d_oe !== 1'b0) begin errors++; $display("FAIL R5 actual=%b expected=0", d_oe); end
        @(negedge clk); rd_n = 1'b0; #2; checks++;
        if (d_oe !== 1'b0) begin errors++; $display("FAIL R5 actual=%b expected=0", d_oe); end
        rd_n = 1'b1; cs_b_n = 1'b0; #2; checks++;
        if (d_oe !== 1'b0) begin errors++; $display("FAIL R5 actual=%b expected=0", d_oe); end
        cs_b_n = 1'b1;
        bus_rd(1'b0, 1'b1, 3'd3, v, oe);
        chk("R5", {7'd0, oe}, 8'h01);

        // R2 R3 R6 R8 sweep, divisor access off then on, all select patterns
        for (int pass = 0; pass < 2; pass++) begin
            if (pass == 1) begin
                bus_wr(1'b1, 1'b1, 3'd3, 8'h83);
                chk_all("R6");
            end
            for (int pat = 0; pat < 3; pat++) begin
                for (int a = 0; a < 8; a++) begin
                    if (a != 3) begin
                        logic [7:0] d = 8'((a * 37 + pat * 91 + pass * 53 + 5) & 8'hFF);
                        bus_wr(pat != 1, pat != 0, 3'(a), d);
                    end
                end
                chk_all(pat == 2 ? "R3" : "R2");
            end
            chk_all(pass == 0 ? "R8" : "R6");
        end

        // R4 read with both selects returns channel A
        bus_wr(1'b1, 1'b0, 3'd7, 8'hA5);
        bus_wr(1'b0, 1'b1, 3'd7, 8'h5A);
        bus_rd(1'b1, 1'b1, 3'd7, v, oe);
        chk("R4", v, 8'hA5);

        // R7 identification window, and leaving it through either byte (R6)
        bus_wr(1'b1, 1'b1, 3'd3, 8'h80);
        bus_wr(1'b1, 1'b1, 3'd0, 8'h00);
        bus_wr(1'b1, 1'b1, 3'd1, 8'h00);
        for (int ch = 0; ch < 2; ch++) begin
            bus_rd(ch == 0, ch == 1, 3'd0, v, oe); chk("R7", v, 8'h01);
            bus_rd(ch == 0, ch == 1, 3'd1, v, oe); chk("R7", v, 8'h06);
        end
        bus_wr(1'b1, 1'b0, 3'd1, 8'h02);
        bus_rd(1'b1, 1'b0, 3'd0, v, oe); chk("R6", v, 8'h00);
        bus_rd(1'b1, 1'b0, 3'd1, v, oe); chk("R6", v, 8'h02);
        bus_rd(1'b0, 1'b1, 3'd0, v, oe); chk("R7", v, 8'h01);
        bus_wr(1'b0, 1'b1, 3'd0, 8'h0C);
        bus_rd(1'b0, 1'b1, 3'd0, v, oe); chk("R6", v, 8'h0C);
        bus_rd(1'b0, 1'b1, 3'd1, v, oe); chk("R6", v, 8'h00);

        // R10 strobe with no select changes nothing
        bus_wr(1'b0, 1'b0, 3'd7, 8'hEE);
        bus_wr(1'b0, 1'b0, 3'd3, 8'h00);
        chk_all("R10");

        // R9 write visible within 6 cycles of strobe release, applied once
        @(negedge clk);
        cs_a_n = 1'b0; addr = 3'd7; d_in = 8'h3C; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1; cs_a_n = 1'b1;
        repeat (6) @(negedge clk);
        m_sp[0] = 8'h3C;
        bus_rd(1'b1, 1'b0, 3'd7, v, oe); chk("R9", v, 8'h3C);
        bus_rd(1'b0, 1'b1, 3'd7, v, oe); chk("R9", v, m_sp[1]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule